// File: doc/BRIEF.md
# Translation Lookaside Buffer with Accessed/Dirty Update Assist

This block is a small fully associative translation cache. Each entry holds a virtual page tag, a physical page number, and local copies of the page's accessed (A) and dirty (D) flags. A lookup compares the requested page against every entry in the same cycle. On a hit the physical page number is returned combinationally. A miss asks an external walker for a fill. When the fill returns, the entry is written into the slot chosen by a round-robin pointer.

A hit is not always the end of the access. If a load hits an entry whose cached A flag is clear, the block stalls the requester and raises an assist request so that the in-memory page entry is updated. It does the same when a store hits an entry whose cached D flag is clear. The assist engine answers with a single-cycle acknowledge. In that cycle the block sets its own copies of the flags and releases the stall.

The cache is deliberately not coherent with memory. A later change to the memory copy of a flag is never seen, so only an explicit flush or a single-page invalidate brings the cached state back in line.

Top module: `tlb_ad_assist`

## Requirements
- R1: After reset no entry is valid. The first lookup of any page misses.
- R2: A lookup that matches no valid entry keeps `rsp_hit` low, holds `rsp_stall` high and raises `fill_req` with `fill_vpn` equal to the requested page. When `fill_valid` is high in such a cycle, the supplied page number and A/D values are stored. The next lookup of that page hits and returns that page number.
- R3: No assist is raised and `rsp_stall` stays low in two cases: a load hitting an entry with A=1, and a store hitting an entry with both A=1 and D=1. In either case `rsp_hit` is 1 and `rsp_ppn` carries the cached physical page.
- R4: A load hitting an entry with A=0 does the following:
  - It raises `asst_req` with `asst_set_a`=1, `asst_set_d`=0 and `asst_vpn` equal to the page.
  - `rsp_hit` is held at 1 and `rsp_stall` at 1 until the cycle in which `asst_ack` is 1. In that cycle `rsp_stall` is 0.
  - After that cycle the same load completes with no assist.
- R5: A store hitting an entry with D=0 raises `asst_req` with `asst_set_d`=1 and `asst_set_a` equal to the inverse of the cached A flag. The acknowledge sets both cached flags as requested.
- R6: Once a cached flag is set, accesses that need it take the fast path with no assist, even if the memory copy of the flag has since been cleared.
- R7: `flush_all` makes every lookup in the same cycle miss and clears every entry, so lookups in later cycles miss.
- R8: `inval_valid` with page `inval_vpn` clears only the entry holding that page. A lookup of that page in the same cycle misses. Other entries keep hitting.
- R9: Fills go to slots in round-robin order. With all slots valid, a new fill replaces the entry that was filled longest ago.
- R10: While `req_valid` is low, `rsp_hit`, `rsp_stall`, `asst_req` and `fill_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present; held with its fields while stalled |
| req_vpn | input | 20 | Virtual page number to translate |
| req_store | input | 1 | 1 for a store, 0 for a load |
| rsp_hit | output | 1 | A valid entry matches the request |
| rsp_ppn | output | 20 | Physical page number on a hit, else 0 |
| rsp_stall | output | 1 | Access cannot complete this cycle |
| fill_req | output | 1 | Miss: a fill is needed |
| fill_vpn | output | 20 | Page to be filled |
| fill_valid | input | 1 | Fill data valid this cycle |
| fill_ppn | input | 20 | Physical page number for the fill |
| fill_a | input | 1 | Accessed flag value to load |
| fill_d | input | 1 | Dirty flag value to load |
| asst_req | output | 1 | Flag update assist requested |
| asst_vpn | output | 20 | Page whose memory entry must be updated |
| asst_set_a | output | 1 | Assist must set the accessed flag |
| asst_set_d | output | 1 | Assist must set the dirty flag |
| asst_ack | input | 1 | One-cycle pulse: memory entry updated |
| flush_all | input | 1 | Invalidate every entry |
| inval_valid | input | 1 | Invalidate one page |
| inval_vpn | input | 20 | Page to invalidate |

## Verification
On every cycle, the checker enforces the following relations between the request and response:
- A pending assist keeps the requester stalled, and the acknowledge cycle releases it.
- A load asks only for the accessed flag.
- A miss never reports a hit.
- A flush or a same-cycle invalidate hides the affected translation.
- Once an acknowledged access is repeated, it needs no further assist.

Round-robin eviction order can only be shown by the bench's scenarios. The same holds for the translated page values and for the fast path continuing after the memory flag is cleared, which relies on the bench's stub memory state.

// File: rtl/tlb_pkg.sv
// Shared widths and the entry record for the translation cache.
// Assumes page numbers of equal width on both sides of the translation.
package tlb_pkg;
    localparam int VPN_W = 20;
    localparam int PPN_W = 20;

    typedef struct packed {
        logic             valid;
        logic             acc;
        logic             dirty;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_rr_ptr.sv
// Round-robin victim pointer: names the slot the next fill writes.
// Assumes one fill at most per cycle; the pointer is not touched by flushes.
module tlb_rr_ptr #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] idx_q;

    // Advance to the next slot, wrapping at the last one, after each fill.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (adv)
            idx_q <= (idx_q == IDX_W'(DEPTH - 1)) ? '0 : idx_q + 1'b1;
    end

    assign idx = idx_q;
endmodule

// File: rtl/tlb_store.sv
// Entry storage with parallel tag compare.
// A flush or an invalidate hides the affected entries from a lookup in the same cycle and clears them at the edge.
// Precedence at the edge: flush, then invalidate, then fill, then flag update.
module tlb_store
    import tlb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_all,
    input  logic             inval_valid,
    input  logic [VPN_W-1:0] inval_vpn,
    input  logic [VPN_W-1:0] look_vpn,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  tlb_entry_t       fill_ent,
    input  logic             upd_we,
    input  logic             upd_a,
    input  logic             upd_d,
    output logic [DEPTH-1:0] hit_vec,
    output tlb_entry_t       hit_ent
);
    tlb_entry_t ent_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic kill;
        assign kill = flush_all | (inval_valid && ent_q[g].vpn == inval_vpn);
        assign hit_vec[g] = ent_q[g].valid && !kill && ent_q[g].vpn == look_vpn;

        // Per-slot state: clear, refill or merge newly set flags.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else if (kill) begin
                ent_q[g].valid <= 1'b0;
            end else if (fill_we && fill_idx == IDX_W'(g)) begin
                ent_q[g] <= fill_ent;
            end else if (upd_we && hit_vec[g]) begin
                ent_q[g].acc   <= ent_q[g].acc | upd_a;
                ent_q[g].dirty <= ent_q[g].dirty | upd_d;
            end
        end
    end

    // Select the matching entry; tags are unique, so an OR merge suffices.
    always_comb begin
        hit_ent = '0;
        for (int i = 0; i < DEPTH; i++)
            if (hit_vec[i]) hit_ent = hit_ent | ent_q[i];
    end
endmodule

// File: rtl/tlb_ad_policy.sv
// Decides whether a hit may complete or needs a flag update in memory.
// Assumes the cached flags belong to the entry that hit.
module tlb_ad_policy (
    input  logic hit,
    input  logic is_store,
    input  logic ent_a,
    input  logic ent_d,
    output logic need,
    output logic set_a,
    output logic set_d
);
    // Loads need A; stores need A and D.
    always_comb begin
        set_a = hit && !ent_a;
        set_d = hit && is_store && !ent_d;
        need  = set_a | set_d;
    end
endmodule

// File: rtl/tlb_ad_assist.sv
// Fully associative translation cache.
// - Misses ask for a fill.
// - Hits missing a needed accessed/dirty flag stall behind an assist handshake.
// Assumes the requester holds req_* stable while rsp_stall is high, and that the fill source and the assist engine each answer with a one-cycle pulse.
module tlb_ad_assist
    import tlb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic             req_store,
    output logic             rsp_hit,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic             rsp_stall,
    output logic             fill_req,
    output logic [VPN_W-1:0] fill_vpn,
    input  logic             fill_valid,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_a,
    input  logic             fill_d,
    output logic             asst_req,
    output logic [VPN_W-1:0] asst_vpn,
    output logic             asst_set_a,
    output logic             asst_set_d,
    input  logic             asst_ack,
    input  logic             flush_all,
    input  logic             inval_valid,
    input  logic [VPN_W-1:0] inval_vpn
);
    logic [DEPTH-1:0] hit_vec;
    tlb_entry_t       hit_ent;
    tlb_entry_t       new_ent;
    logic [IDX_W-1:0] victim;
    logic             hit_any, need, set_a, set_d, fill_we;

    assign hit_any = req_valid && |hit_vec;
    assign fill_we = fill_req && fill_valid;
    assign new_ent = '{valid: 1'b1, acc: fill_a, dirty: fill_d,
                       vpn: req_vpn, ppn: fill_ppn};

    tlb_store #(.DEPTH(DEPTH)) i_store (
        .clk(clk), .rst_n(rst_n),
        .flush_all(flush_all), .inval_valid(inval_valid), .inval_vpn(inval_vpn),
        .look_vpn(req_vpn),
        .fill_we(fill_we), .fill_idx(victim), .fill_ent(new_ent),
        .upd_we(need && asst_ack), .upd_a(set_a), .upd_d(set_d),
        .hit_vec(hit_vec), .hit_ent(hit_ent)
    );

    tlb_rr_ptr #(.DEPTH(DEPTH)) i_rr (
        .clk(clk), .rst_n(rst_n), .adv(fill_we), .idx(victim)
    );

    tlb_ad_policy i_policy (
        .hit(hit_any), .is_store(req_store),
        .ent_a(hit_ent.acc), .ent_d(hit_ent.dirty),
        .need(need), .set_a(set_a), .set_d(set_d)
    );

    // Response and request outputs; the stall clears in the acknowledge cycle.
    always_comb begin
        rsp_hit    = hit_any;
        rsp_ppn    = hit_any ? hit_ent.ppn : '0;
        fill_req   = req_valid && !hit_any;
        fill_vpn   = req_vpn;
        asst_req   = need;
        asst_vpn   = req_vpn;
        asst_set_a = set_a;
        asst_set_d = set_d;
        rsp_stall  = fill_req || (need && !asst_ack);
    end
endmodule

// File: rtl/tlb_ad_assist_chk.sv
// Cycle-by-cycle protocol checks for tlb_ad_assist, attached by bind.
module tlb_ad_assist_chk #(
    parameter int VW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [VW-1:0] req_vpn,
    input logic          req_store,
    input logic          rsp_hit,
    input logic          rsp_stall,
    input logic          fill_req,
    input logic          asst_req,
    input logic          asst_set_a,
    input logic          asst_set_d,
    input logic          asst_ack,
    input logic          flush_all,
    input logic          inval_valid,
    input logic [VW-1:0] inval_vpn
);
    p_miss_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> (!rsp_hit && rsp_stall));

    p_stall_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (asst_req && !asst_ack) |-> (rsp_stall && rsp_hit));

    p_ack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (asst_req && asst_ack) |-> !rsp_stall);

    p_load_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (asst_req && !req_store) |-> (asst_set_a && !asst_set_d));

    p_acked_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(asst_req && asst_ack && !flush_all && !inval_valid)
         && req_vpn == $past(req_vpn) && req_store == $past(req_store))
        |-> (rsp_hit && !asst_req));

    p_flush_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !rsp_hit);

    p_inval_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_valid && req_valid && req_vpn == inval_vpn) |-> (!rsp_hit && fill_req));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!rsp_hit && !rsp_stall && !asst_req && !fill_req));
endmodule

bind tlb_ad_assist tlb_ad_assist_chk #(.VW(tlb_pkg::VPN_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
    .req_store(req_store), .rsp_hit(rsp_hit), .rsp_stall(rsp_stall),
    .fill_req(fill_req), .asst_req(asst_req), .asst_set_a(asst_set_a),
    .asst_set_d(asst_set_d), .asst_ack(asst_ack), .flush_all(flush_all),
    .inval_valid(inval_valid), .inval_vpn(inval_vpn)
);

// File: tb/test_tlb_ad_assist.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module test_tlb_ad_assist;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0;
    logic [19:0] req_vpn = '0;
    logic        rsp_hit, rsp_stall, fill_req, asst_req, asst_set_a, asst_set_d;
    logic [19:0] rsp_ppn, fill_vpn, asst_vpn;
    logic        fill_valid = 1'b0, fill_a = 1'b0, fill_d = 1'b0;
    logic [19:0] fill_ppn = '0;
    logic        asst_ack = 1'b0, flush_all = 1'b0, inval_valid = 1'b0;
    logic [19:0] inval_vpn = '0;
    int          n_chk = 0, n_err = 0;
    logic        mem_d_200;   // stub memory copy of D for page 0x00200

    always #2.5 clk = ~clk;   // 200 MHz

    tlb_ad_assist i_tlb_ad_assist (.*);

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Present a request at the falling edge; outputs are sampled 1 ns later.
    task automatic look(input logic [19:0] v, input logic st);
        @(negedge clk);
        req_valid = 1'b1; req_vpn = v; req_store = st;
        fill_valid = 1'b0; asst_ack = 1'b0; flush_all = 1'b0; inval_valid = 1'b0;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; fill_valid = 1'b0; asst_ack = 1'b0;
        flush_all = 1'b0; inval_valid = 1'b0;
        #1;
    endtask

    // Miss then fill; checks the miss side of R2.
    task automatic do_fill(input logic [19:0] v, input logic [19:0] p, input logic a, input logic d);
        look(v, 1'b0);
        chk(fill_req && !rsp_hit && rsp_stall && fill_vpn == v, "R2 miss", {fill_req, rsp_hit, rsp_stall}, 3'b101);
        fill_valid = 1'b1; fill_ppn = p; fill_a = a; fill_d = d;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic t_reset();
        idle();
        chk(!rsp_hit && !rsp_stall && !asst_req && !fill_req, "R10 idle", {rsp_hit, rsp_stall, asst_req, fill_req}, 0);
        look(20'h12345, 1'b0);
        chk(!rsp_hit && fill_req, "R1 empty after reset", rsp_hit, 0);
    endtask

    task automatic t_fill_hit();
        do_fill(20'h12345, 20'hABCDE, 1'b1, 1'b1);
        look(20'h12345, 1'b0);
        chk(rsp_hit && rsp_ppn == 20'hABCDE, "R2 filled ppn", rsp_ppn, 20'hABCDE);
        chk(!rsp_stall && !asst_req, "R3 load fast path", {rsp_stall, asst_req}, 0);
        look(20'h12345, 1'b1);
        chk(rsp_hit && !rsp_stall && !asst_req, "R3 store fast path", {rsp_hit, rsp_stall, asst_req}, 3'b100);
    endtask

    task automatic t_a_assist();
        do_fill(20'h00100, 20'h00555, 1'b0, 1'b0);
        look(20'h00100, 1'b0);
        chk(rsp_hit && rsp_stall && asst_req && asst_vpn == 20'h00100, "R4 assist raised", {rsp_hit, rsp_stall, asst_req}, 3'b111);
        chk(asst_set_a && !asst_set_d, "R4 load flags", {asst_set_a, asst_set_d}, 2'b10);
        @(negedge clk); #1;
        chk(rsp_stall && asst_req, "R4 stall held", rsp_stall, 1);
        asst_ack = 1'b1; #0.1;
        chk(!rsp_stall && rsp_hit, "R4 ack releases", rsp_stall, 0);
        look(20'h00100, 1'b0);
        chk(!asst_req && !rsp_stall && rsp_ppn == 20'h00555, "R4 A now cached", asst_req, 0);
    endtask

    task automatic t_d_assist();
        do_fill(20'h00200, 20'h00777, 1'b0, 1'b0);
        look(20'h00200, 1'b1);
        chk(asst_req && asst_set_a && asst_set_d, "R5 store A=0 D=0", {asst_set_a, asst_set_d}, 2'b11);
        asst_ack = 1'b1; mem_d_200 = 1'b1; #0.1;
        chk(!rsp_stall, "R5 ack releases", rsp_stall, 0);
        do_fill(20'h00300, 20'h00888, 1'b1, 1'b0);
        look(20'h00300, 1'b0);
        chk(!asst_req && !rsp_stall, "R3 load on A=1 D=0", asst_req, 0);
        look(20'h00300, 1'b1);
        chk(asst_req && !asst_set_a && asst_set_d, "R5 store A=1 D=0", {asst_set_a, asst_set_d}, 2'b01);
        asst_ack = 1'b1; #0.1;
        look(20'h00300, 1'b1);
        chk(!asst_req && !rsp_stall, "R5 D cached", asst_req, 0);
    endtask

    task automatic t_noncoherent();
        mem_d_200 = 1'b0;   // software clears the memory copy; no flush follows
        look(20'h00200, 1'b1);
        chk(rsp_hit && !asst_req && !rsp_stall && !mem_d_200, "R6 stale fast path", asst_req, 0);
    endtask

    task automatic t_inval();
        look(20'h12345, 1'b0);
        inval_valid = 1'b1; inval_vpn = 20'h12345; #0.1;
        chk(!rsp_hit && fill_req, "R8 same-cycle miss", rsp_hit, 0);
        look(20'h12345, 1'b0);
        chk(!rsp_hit, "R8 entry gone", rsp_hit, 0);
        look(20'h00100, 1'b0);
        chk(rsp_hit && rsp_ppn == 20'h00555, "R8 other entry kept", rsp_ppn, 20'h00555);
    endtask

    task automatic t_flush();
        look(20'h00100, 1'b0);
        flush_all = 1'b1; #0.1;
        chk(!rsp_hit, "R7 same-cycle miss", rsp_hit, 0);
        look(20'h00100, 1'b0);
        chk(!rsp_hit, "R7 flushed 00100", rsp_hit, 0);
        look(20'h00300, 1'b0);
        chk(!rsp_hit, "R7 flushed 00300", rsp_hit, 0);
    endtask

    task automatic t_rr();
        for (int i = 0; i < 8; i++) do_fill(20'h01000 + 20'(i), 20'h0F000 + 20'(i), 1'b1, 1'b1);
        for (int i = 0; i < 8; i++) begin
            look(20'h01000 + 20'(i), 1'b0);
            chk(rsp_hit && rsp_ppn == 20'h0F000 + 20'(i), "R9 all slots", rsp_ppn, 20'h0F000 + 20'(i));
        end
        do_fill(20'h02000, 20'h0E000, 1'b1, 1'b1);
        look(20'h01000, 1'b0);
        chk(!rsp_hit, "R9 oldest evicted", rsp_hit, 0);
        for (int i = 1; i < 8; i++) begin
            look(20'h01000 + 20'(i), 1'b0);
            chk(rsp_hit, "R9 others kept", rsp_hit, 1);
        end
        look(20'h02000, 1'b0);
        chk(rsp_hit && rsp_ppn == 20'h0E000, "R9 new entry", rsp_ppn, 20'h0E000);
    endtask

    initial begin
        #(200000 * 5);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_hit();
        t_a_assist();
        t_d_assist();
        t_noncoherent();
        t_inval();
        t_flush();
        t_rr();
        idle();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule